// File: doc/BRIEF.md
# Rational Sample-Rate Strobe Generator

This block turns fast reference tick streams into audio sample-rate strobes. Each of several generators holds a numerator N and a denominator M. It keeps a running error term. On every tick of its chosen reference it adds N to that term. When the sum reaches M it removes M and emits a one-cycle strobe. Over any run the strobe rate is exactly N/M of the reference rate, so almost any sample rate can be reached from a few fixed references. Examples are 48, 44.1, 32, 16 and 8 kHz, and a reference recovered from an incoming digital stream can be one of the choices.

By default there are three generators: index 0 for digital output, 1 for analog capture and 2 for analog playback. Each picks one of three reference tick inputs. A link mode makes the capture generator reproduce the playback generator's strobe, so both converter directions share one rate when four channels run together. Software programs the block through a single write port that carries a generator index, a field code and a data word.

Top module: `frac_rate_gen`

## Requirements
- R1: A generator's strobe rises only in the cycle after a tick of its selected reference. It lasts exactly one cycle per accepted tick.
- R2: On each accepted tick the error term grows by N. When it reaches M it is reduced by M and a strobe follows. After a clear, t accepted ticks yield exactly floor(t*N/M) strobes, and the term stays below M.
- R3: With N equal to M and M nonzero, every accepted tick produces a strobe.
- R4: A write of field 0, 1 or 2 to a generator clears its error term and suppresses its strobe in the following cycle. A tick in the write cycle is not counted.
- R5: A generator whose M is zero or whose N exceeds M ignores all ticks and never strobes. Its error term stays at zero.
- R6: Field 0 selects the reference: value 0, 1 or 2 picks ref_tick_i bit 0, 1 or 2. Value 3 selects no reference, and then the generator does not strobe.
- R7: Field 3 sets link mode from data bit 0. While link mode is set, strobe_o[1] equals strobe_o[2] every cycle. A field-3 write clears the error terms of generators 1 and 2.
- R8: After reset every strobe is low. Every generator then has field 0 = 3, N = 0, M = 0 and link mode off.
- R9: Field codes are 0 = reference select, 1 = N, 2 = M, 3 = link. New settings apply from the cycle after the write. Writes of fields 0 to 2 with a generator index of 3 or more change nothing. Generators never affect one another except through link mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 3 | One-cycle tick per reference timebase |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_gen_i | input | 2 | Generator index of the write |
| cfg_field_i | input | 2 | Field code of the write |
| cfg_data_i | input | 16 | Write data |
| strobe_o | output | 3 | One sample strobe per generator |

## Verification
The assertions assume that a write lasts one cycle and that reference ticks are single-cycle levels sampled on the clock. They also assume that an index of 3 or more never targets a generator. The unit-ratio property only applies in cycles with no write. The bench drives ticks from three fixed patterns: every cycle, every third cycle, and a pseudo-random sequence. It issues writes one at a time from a task that holds cfg_we_i for exactly one cycle, so every stimulus stays within these assumptions. Rejected ratios, the empty reference selection and out-of-range indices still go through that same port.

// File: rtl/frac_rate_pkg.sv
package frac_rate_pkg;
  typedef enum logic [1:0] {
    FLD_TBSEL = 2'd0,
    FLD_NUM   = 2'd1,
    FLD_DEN   = 2'd2,
    FLD_LINK  = 2'd3
  } cfg_field_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/frac_rate_tbsel.sv
module frac_rate_tbsel #(
  parameter int unsigned NUM_REF = 3,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_REF-1:0] ref_tick_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               enable_i,
  output logic               tick_o
);
  logic picked;

  always_comb begin
    picked = 1'b0;
    for (int k = 0; k < NUM_REF; k++) begin
      if (sel_i == SEL_W'(k)) picked = ref_tick_i[k];
    end
    tick_o = enable_i & picked;
  end
endmodule

// File: rtl/frac_rate_acc.sv
module frac_rate_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         tick_i,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] acc_o,
  output logic         strobe_o
);
  logic [W:0]   sum;
  logic [W:0]   diff;
  logic [W-1:0] acc_q, acc_d;
  logic         stb_q, stb_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, num_i};
    diff  = sum - {1'b0, den_i};
    acc_d = acc_q;
    stb_d = 1'b0;
    if (clear_i) begin
      acc_d = '0;
    end else if (tick_i) begin
      if (sum >= {1'b0, den_i}) begin
        acc_d = diff[W-1:0];
        stb_d = 1'b1;
      end else begin
        acc_d = sum[W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      stb_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      stb_q <= stb_d;
    end
  end

  assign acc_o    = acc_q;
  assign strobe_o = stb_q;
endmodule

// File: rtl/frac_rate_chan.sv
module frac_rate_chan #(
  parameter int unsigned NUM_REF = 3,
  parameter int unsigned W       = 16,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel_i,
  input  logic               wr_num_i,
  input  logic               wr_den_i,
  input  logic               clear_i,
  input  logic [W-1:0]       wdata_i,
  input  logic [NUM_REF-1:0] ref_tick_i,
  output logic               strobe_o,
  output logic               tick_o,
  output logic               valid_o,
  output logic [W-1:0]       acc_o,
  output logic [W-1:0]       num_o,
  output logic [W-1:0]       den_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [W-1:0]     num_q, num_d;
  logic [W-1:0]     den_q, den_d;
  logic             ratio_ok;

  always_comb begin
    sel_d = wr_sel_i ? wdata_i[SEL_W-1:0] : sel_q;
    num_d = wr_num_i ? wdata_i : num_q;
    den_d = wr_den_i ? wdata_i : den_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '1;
      num_q <= '0;
      den_q <= '0;
    end else begin
      sel_q <= sel_d;
      num_q <= num_d;
      den_q <= den_d;
    end
  end

  assign ratio_ok = (den_q != '0) && (num_q <= den_q);
  assign valid_o  = ratio_ok && ({{(32-SEL_W){1'b0}}, sel_q} < NUM_REF);

  frac_rate_tbsel #(
    .NUM_REF (NUM_REF),
    .SEL_W   (SEL_W)
  ) u_tbsel (
    .ref_tick_i (ref_tick_i),
    .sel_i      (sel_q),
    .enable_i   (valid_o),
    .tick_o     (tick_o)
  );

  frac_rate_acc #(
    .W (W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (clear_i),
    .tick_i   (tick_o),
    .num_i    (num_q),
    .den_i    (den_q),
    .acc_o    (acc_o),
    .strobe_o (strobe_o)
  );

  assign num_o = num_q;
  assign den_o = den_q;
endmodule

// File: rtl/frac_rate_gen.sv
module frac_rate_gen
  import frac_rate_pkg::*;
#(
  parameter int unsigned NUM_GEN    = 3,
  parameter int unsigned NUM_REF    = 3,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned LEAD_GEN   = 2,
  parameter int unsigned FOLLOW_GEN = 1,
  localparam int unsigned GEN_W     = (NUM_GEN > 1) ? $clog2(NUM_GEN + 1) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REF-1:0] ref_tick_i,
  input  logic               cfg_we_i,
  input  logic [GEN_W-1:0]   cfg_gen_i,
  input  logic [1:0]         cfg_field_i,
  input  logic [ACC_W-1:0]   cfg_data_i,
  output logic [NUM_GEN-1:0] strobe_o
);
  logic                          link_q, link_d;
  logic                          link_wr;
  logic [NUM_GEN-1:0]            own_strobe;
  logic [NUM_GEN-1:0]            gen_tick;
  logic [NUM_GEN-1:0]            gen_valid;
  logic [NUM_GEN-1:0][ACC_W-1:0] acc_w;
  logic [NUM_GEN-1:0][ACC_W-1:0] num_w;
  logic [NUM_GEN-1:0][ACC_W-1:0] den_w;

  assign link_wr = cfg_we_i && (cfg_field_e'(cfg_field_i) == FLD_LINK);

  always_comb begin
    link_d = link_wr ? cfg_data_i[0] : link_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) link_q <= 1'b0;
    else        link_q <= link_d;
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
    logic hit, wr_sel, wr_num, wr_den, clr;
    assign hit    = cfg_we_i && (cfg_gen_i == GEN_W'(g));
    assign wr_sel = hit && (cfg_field_e'(cfg_field_i) == FLD_TBSEL);
    assign wr_num = hit && (cfg_field_e'(cfg_field_i) == FLD_NUM);
    assign wr_den = hit && (cfg_field_e'(cfg_field_i) == FLD_DEN);
    if ((g == LEAD_GEN) || (g == FOLLOW_GEN)) begin : g_linked
      assign clr = wr_sel || wr_num || wr_den || link_wr;
    end else begin : g_plain
      assign clr = wr_sel || wr_num || wr_den;
    end

    frac_rate_chan #(
      .NUM_REF (NUM_REF),
      .W       (ACC_W),
      .SEL_W   (SEL_W)
    ) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_sel_i   (wr_sel),
      .wr_num_i   (wr_num),
      .wr_den_i   (wr_den),
      .clear_i    (clr),
      .wdata_i    (cfg_data_i),
      .ref_tick_i (ref_tick_i),
      .strobe_o   (own_strobe[g]),
      .tick_o     (gen_tick[g]),
      .valid_o    (gen_valid[g]),
      .acc_o      (acc_w[g]),
      .num_o      (num_w[g]),
      .den_o      (den_w[g])
    );

    if (g == FOLLOW_GEN) begin : g_follow
      assign strobe_o[g] = link_q ? own_strobe[LEAD_GEN] : own_strobe[g];
    end else begin : g_direct
      assign strobe_o[g] = own_strobe[g];
    end
  end
endmodule

// File: rtl/frac_rate_gen_chk.sv
module frac_rate_gen_chk #(
  parameter int unsigned NUM_GEN    = 3,
  parameter int unsigned ACC_W      = 16,
  parameter int unsigned LEAD_GEN   = 2,
  parameter int unsigned FOLLOW_GEN = 1,
  parameter int unsigned GEN_W      = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cfg_we_i,
  input logic [GEN_W-1:0]              cfg_gen_i,
  input logic [1:0]                    cfg_field_i,
  input logic [NUM_GEN-1:0]            strobe_o,
  input logic                          link_q,
  input logic [NUM_GEN-1:0]            own_strobe,
  input logic [NUM_GEN-1:0]            gen_tick,
  input logic [NUM_GEN-1:0]            gen_valid,
  input logic [NUM_GEN-1:0][ACC_W-1:0] acc_w,
  input logic [NUM_GEN-1:0][ACC_W-1:0] num_w,
  input logic [NUM_GEN-1:0][ACC_W-1:0] den_w
);
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_prop
    p_strobe_after_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      own_strobe[g] |-> $past(gen_tick[g]));

    p_acc_below_den_r2: assert property (@(posedge clk) disable iff (!rst_n)
      gen_valid[g] |-> (acc_w[g] < den_w[g]));

    p_unit_ratio_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (gen_tick[g] && !cfg_we_i && (num_w[g] == den_w[g])) |=> own_strobe[g]);

    p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we_i && (cfg_field_i != 2'd3) && (cfg_gen_i == GEN_W'(g)))
        |=> ((acc_w[g] == '0) && !own_strobe[g]));

    p_idle_when_rejected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_valid[g] |-> (acc_w[g] == '0));
  end

  p_link_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_q |-> (strobe_o[FOLLOW_GEN] == strobe_o[LEAD_GEN]));

  p_link_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && (cfg_field_i == 2'd3))
      |=> ((acc_w[LEAD_GEN] == '0) && (acc_w[FOLLOW_GEN] == '0)));
endmodule

bind frac_rate_gen frac_rate_gen_chk #(
  .NUM_GEN    (NUM_GEN),
  .ACC_W      (ACC_W),
  .LEAD_GEN   (LEAD_GEN),
  .FOLLOW_GEN (FOLLOW_GEN),
  .GEN_W      (GEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we_i    (cfg_we_i),
  .cfg_gen_i   (cfg_gen_i),
  .cfg_field_i (cfg_field_i),
  .strobe_o    (strobe_o),
  .link_q      (link_q),
  .own_strobe  (own_strobe),
  .gen_tick    (gen_tick),
  .gen_valid   (gen_valid),
  .acc_w       (acc_w),
  .num_w       (num_w),
  .den_w       (den_w)
);

// File: tb/tb_frac_rate_gen.sv
module tb_frac_rate_gen;
  logic        clk;
  logic        rst_n;
  logic [2:0]  ref_tick_i;
  logic        cfg_we_i;
  logic [1:0]  cfg_gen_i;
  logic [1:0]  cfg_field_i;
  logic [15:0] cfg_data_i;
  logic [2:0]  strobe_o;

  frac_rate_gen dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_tick_i  (ref_tick_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_gen_i   (cfg_gen_i),
    .cfg_field_i (cfg_field_i),
    .cfg_data_i  (cfg_data_i),
    .strobe_o    (strobe_o)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string cur_req = "R8";

  // behavioural model state
  int m_sel[3], m_num[3], m_den[3], m_acc[3];
  bit m_own[3];
  bit m_link;
  int tcnt[3];
  int scnt[3];

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic bit exp_bit(int g);
    if (g == 1 && m_link) return m_own[2];
    return m_own[g];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin
        m_sel[g] = 3; m_num[g] = 0; m_den[g] = 0; m_acc[g] = 0; m_own[g] = 0;
        tcnt[g] = 0;
      end
      m_link = 0;
    end else begin
      for (int k = 0; k < 3; k++) tcnt[k] += ref_tick_i[k];
      for (int g = 0; g < 3; g++) begin
        bit wr;
        wr = cfg_we_i && ((cfg_field_i != 3 && cfg_gen_i == g) ||
                          (cfg_field_i == 3 && g != 0));
        if (wr) begin
          if (cfg_field_i == 0) m_sel[g] = cfg_data_i[1:0];
          if (cfg_field_i == 1) m_num[g] = cfg_data_i;
          if (cfg_field_i == 2) m_den[g] = cfg_data_i;
          m_acc[g] = 0;
          m_own[g] = 0;
        end else if (m_den[g] != 0 && m_num[g] <= m_den[g] && m_sel[g] < 3
                     && ref_tick_i[m_sel[g]]) begin
          m_acc[g] += m_num[g];
          if (m_acc[g] >= m_den[g]) begin
            m_acc[g] -= m_den[g];
            m_own[g] = 1;
          end else m_own[g] = 0;
        end else m_own[g] = 0;
      end
      if (cfg_we_i && cfg_field_i == 3) m_link = cfg_data_i[0];
    end
  end

  // per-cycle comparison and strobe counting, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      for (int g = 0; g < 3; g++) begin
        scnt[g] += strobe_o[g];
        checks++;
        if (strobe_o[g] !== exp_bit(g)) begin
          fails++;
          $display("FAIL %s gen%0d strobe actual=%b expected=%b at %0t",
                   cur_req, g, strobe_o[g], exp_bit(g), $time);
        end
      end
    end else begin
      for (int g = 0; g < 3; g++) scnt[g] = 0;
    end
  end

  // reference tick patterns: every cycle, every third cycle, pseudo-random
  initial begin
    logic [7:0] lfsr;
    int cyc;
    lfsr = 8'hA5;
    cyc = 0;
    ref_tick_i = '0;
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ref_tick_i[0] = 1'b1;
      ref_tick_i[1] = (cyc % 3 == 0);
      ref_tick_i[2] = lfsr[0];
      cyc++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input int gen, input int field, input int data);
    @(negedge clk);
    cfg_we_i = 1; cfg_gen_i = 2'(gen); cfg_field_i = 2'(field);
    cfg_data_i = 16'(data);
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  // counts ticks and strobes over a window that starts just after a write
  task automatic window(input int g, input int ref_k, input int cycles,
                        input int n, input int m, input string req);
    int t0, s0, dt, ds;
    #1;
    t0 = tcnt[ref_k]; s0 = scnt[g];
    repeat (cycles) @(negedge clk);
    #1;
    dt = tcnt[ref_k] - t0; ds = scnt[g] - s0;
    check(ds == (m == 0 ? 0 : (dt * n) / m), req, "strobe count",
          ds, (m == 0 ? 0 : (dt * n) / m));
  endtask

  task automatic setup(input int g, input int sel, input int n, input int m);
    cfg_write(g, 0, sel);
    cfg_write(g, 1, n);
    cfg_write(g, 2, m);
  endtask

  initial begin
    rst_n = 0; cfg_we_i = 0; cfg_gen_i = 0; cfg_field_i = 0; cfg_data_i = 0;
    repeat (3) @(negedge clk);
    #1;
    check(strobe_o == 3'b000, "R8", "strobes in reset", strobe_o, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    #1;
    check(scnt[0] + scnt[1] + scnt[2] == 0, "R8", "strobes after reset",
          scnt[0] + scnt[1] + scnt[2], 0);

    cur_req = "R3";
    setup(0, 0, 1, 1);
    window(0, 0, 40, 1, 1, "R3");
    cur_req = "R2";
    setup(2, 1, 147, 160);
    window(2, 1, 600, 147, 160, "R2");
    setup(1, 2, 2, 3);
    window(1, 2, 300, 2, 3, "R2");
    setup(0, 0, 1, 6);
    window(0, 0, 120, 1, 6, "R2");
    setup(2, 0, 441, 1000);
    window(2, 0, 500, 441, 1000, "R2");

    cur_req = "R6";
    cfg_write(1, 0, 1);
    window(1, 1, 90, 2, 3, "R6");
    cfg_write(1, 0, 3);
    window(1, 0, 60, 0, 1, "R6");
    cfg_write(1, 0, 2);

    cur_req = "R5";
    setup(0, 0, 5, 4);
    window(0, 0, 50, 0, 1, "R5");
    cfg_write(0, 2, 0);
    window(0, 0, 50, 0, 1, "R5");
    cfg_write(0, 2, 4);
    cfg_write(0, 1, 3);
    window(0, 0, 80, 3, 4, "R5");

    cur_req = "R4";
    repeat (7) @(negedge clk);
    cfg_write(0, 1, 3);
    window(0, 0, 41, 3, 4, "R4");
    for (int i = 0; i < 5; i++) begin
      cfg_write(2, 2, 1000);
      repeat (i + 2) @(negedge clk);
    end

    cur_req = "R9";
    cfg_write(3, 1, 9);
    cfg_write(3, 2, 0);
    window(0, 0, 40, 3, 4, "R9");

    cur_req = "R7";
    setup(2, 1, 1, 2);
    cfg_write(0, 3, 1);
    window(1, 1, 150, 1, 2, "R7");
    cfg_write(0, 3, 0);
    window(1, 2, 150, 2, 3, "R7");

    repeat (10) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule